// File: doc/BRIEF.md
# DS3/E3 Maintenance Condition Detector

This block sits behind a DS3 or E3 framer that has already found alignment. For every received bit it gets the bit value, a valid strobe, a flag that marks overhead bits, and the subframe and block numbers of the current bit. It also gets the framer's in-frame, parity-good, loss-of-signal and out-of-frame indications. From these it classifies the stream once per M-frame and drives four active-high status outputs: the line format code, the idle-signal flag, the remote (yellow) alarm and the alarm indication signal (AIS).

In DS3 mode the block tracks the overhead positions of the M-frame. That frame has seven subframes of eight blocks, and each block is one overhead bit followed by 84 payload bits. In each subframe, block 0 carries X, P or M, the odd blocks carry F bits, and blocks 2, 4 and 6 carry the three C-bits. The block checks every payload bit against the expected AIS and idle patterns, and both patterns restart after each overhead bit. In E3 mode it takes yellow from the A-bit, which the framer marks with the overhead flag. It finds AIS by counting zeros over a fixed window of valid bits. The format and idle outputs stay at zero in E3 mode.

Top module: `ds3_maint_det`

## Requirements
- R1: In DS3 mode, at the end of each M-frame with in-frame held and parity good, the first C-bit of subframe index 0 (block 2) is compared with its value in the previous good M-frame. The format code becomes 2'b01 (C-bit parity) if both values are 1, 2'b00 (M13) if both are 0, and 2'b10 (Syntran) if they differ. It is never 2'b11. The first good frame after reset, or after a bad frame, only stores the bit and leaves the code unchanged.
- R2: In DS3 mode, AIS is set at M-frame end only if all of the following hold: in-frame stayed high on every valid bit of the frame, parity is good, all 21 C-bits were 0, and the two X-bits (block 0 of subframes 0 and 1) were equal. The payload must also match 1,0,1,0... after each overhead bit.
- R3: In DS3 mode, idle is set at M-frame end only if all of the following hold: the frame passed the same framing and parity test, the three C-bits of subframe index 2 were 0, the X-bits were equal, and the payload matched 1,1,0,0,1,1,0,0... after each overhead bit. Idle and AIS are never high together.
- R4: A single payload bit that differs from a pattern clears that pattern's flag for the M-frame. The pattern phase restarts at each overhead bit.
- R5: In DS3 mode, yellow is set at M-frame end when both X-bits of that frame were 0, and it holds for exactly the next M-frame interval.
- R6: Yellow is forced low on the clock after losIn or oofIn is high, and it is never high while aisFlag is high.
- R7: In E3 mode, at each frame end (frameEnd with bitValid), yellow takes the value of the last bit marked with ovhFlag (the A-bit), subject to R6.
- R8: In E3 mode, AIS is set at the end of every 1536-bit window of valid bits if that window held at most 2 zero bits, and cleared otherwise. The window is counted from reset.
- R9: In E3 mode, the idle flag and the format code stay 0.
- R10: Cycles with bitValid low change no state. AIS changes only at an M-frame end (DS3) or a window end (E3). Idle changes only at an M-frame end.
- R11: After reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| e3Mode | input | 1 | 1 selects E3 classification, 0 selects DS3 |
| bitValid | input | 1 | The bit inputs carry a received bit this cycle |
| bitData | input | 1 | Received bit value |
| ovhFlag | input | 1 | Bit is an overhead bit (DS3) or the A-bit (E3) |
| subIdx | input | 3 | DS3 subframe index 0..6 of the bit |
| blkIdx | input | 3 | DS3 block index 0..7 within the subframe |
| frameEnd | input | 1 | Bit is the last bit of the frame |
| inFrame | input | 1 | Framer reports alignment |
| parityOk | input | 1 | Framer reports good parity for the frame ending now |
| losIn | input | 1 | Loss-of-signal alarm |
| oofIn | input | 1 | Out-of-frame alarm |
| fmtCode | output | 2 | Line format code |
| idleFlag | output | 1 | Idle signal detected |
| yellowFlag | output | 1 | Remote alarm detected |
| aisFlag | output | 1 | Alarm indication signal detected |

## Verification
The DS3 main function is driven with whole M-frames carrying AIS payload, idle payload or random payload. Each payload is combined with C-bit and X-bit settings that meet a pattern's overhead rules or break exactly one of them. This separates a payload mismatch from a C-bit, X-bit, in-frame or parity fault. Sequences of the first C-bit across frames step the format code through all three values. In E3 mode, windows with zero, two and three zero bits find the exact AIS threshold. A-bit settings together with alarm pulses show yellow being set, held and suppressed.

// File: rtl/ds3mon_pkg.sv
package ds3mon_pkg;

  typedef enum logic [1:0] {
    OVH_XBIT = 2'd0,
    OVH_PMBIT = 2'd1,
    OVH_FBIT = 2'd2,
    OVH_CBIT = 2'd3
  } ovhKind_t;

  typedef struct packed {
    logic dsBit;
    logic e3Bit;
    logic dataBit;
    logic payStb;
    logic xFirst;
    logic xSecond;
    logic cBit;
    logic cSub3;
    logic aicBit;
    logic aBit;
    logic expAis;
    logic expIdle;
    logic frameDs;
    logic frameE3;
    logic winEnd;
  } ctrlStb_t;

  localparam logic [1:0] FMT_M13 = 2'b00;
  localparam logic [1:0] FMT_CBIT = 2'b01;
  localparam logic [1:0] FMT_SYNTRAN = 2'b10;

endpackage

// File: rtl/ds3mon_ctrl.sv
module ds3mon_ctrl
  import ds3mon_pkg::*;
#(
  parameter int SUB_W = 3,
  parameter int BLK_W = 3,
  parameter int E3_WIN = 1536
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             e3Mode,
  input  logic             bitValid,
  input  logic             bitData,
  input  logic             ovhFlag,
  input  logic [SUB_W-1:0] subIdx,
  input  logic [BLK_W-1:0] blkIdx,
  input  logic             frameEnd,
  output ctrlStb_t         stb
);

  localparam int WIN_W = $clog2(E3_WIN);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(E3_WIN - 1);
  localparam logic [SUB_W-1:0] SUB_X1 = SUB_W'(0);
  localparam logic [SUB_W-1:0] SUB_X2 = SUB_W'(1);
  localparam logic [SUB_W-1:0] SUB_IDLE = SUB_W'(2);
  localparam logic [BLK_W-1:0] BLK_AIC = BLK_W'(2);

  logic [1:0]       payPos;
  logic [WIN_W-1:0] winCnt;
  ovhKind_t         kind;
  logic             dsValid;
  logic             e3Valid;

  function automatic ovhKind_t classify(input logic [SUB_W-1:0] s, input logic [BLK_W-1:0] b);
    if (b == '0) begin
      if (s == SUB_X1 || s == SUB_X2) return OVH_XBIT;
      return OVH_PMBIT;
    end
    if (b[0]) return OVH_FBIT;
    return OVH_CBIT;
  endfunction

  assign dsValid = bitValid & ~e3Mode;
  assign e3Valid = bitValid & e3Mode;
  assign kind = classify(subIdx, blkIdx);

  // payload phase within the current block, restarted by each overhead bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      payPos <= '0;
    end else if (bitValid) begin
      if (ovhFlag) payPos <= '0;
      else payPos <= payPos + 2'd1;
    end
  end

  // E3 window counter, only runs in E3 mode
  always_ff @(posedge clk) begin
    if (!rstN || !e3Mode) begin
      winCnt <= '0;
    end else if (bitValid) begin
      if (winCnt == WIN_LAST) winCnt <= '0;
      else winCnt <= winCnt + 1'b1;
    end
  end

  always_comb begin
    stb = '0;
    stb.dsBit = dsValid;
    stb.e3Bit = e3Valid;
    stb.dataBit = bitData;
    stb.payStb = dsValid & ~ovhFlag;
    stb.xFirst = dsValid & ovhFlag & (kind == OVH_XBIT) & (subIdx == SUB_X1);
    stb.xSecond = dsValid & ovhFlag & (kind == OVH_XBIT) & (subIdx == SUB_X2);
    stb.cBit = dsValid & ovhFlag & (kind == OVH_CBIT);
    stb.cSub3 = dsValid & ovhFlag & (kind == OVH_CBIT) & (subIdx == SUB_IDLE);
    stb.aicBit = dsValid & ovhFlag & (kind == OVH_CBIT) & (subIdx == SUB_X1) & (blkIdx == BLK_AIC);
    stb.aBit = e3Valid & ovhFlag;
    stb.expAis = ~payPos[0];
    stb.expIdle = ~payPos[1];
    stb.frameDs = dsValid & frameEnd;
    stb.frameE3 = e3Valid & frameEnd;
    stb.winEnd = e3Valid & (winCnt == WIN_LAST);
  end

  p_win_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_LAST);

  p_phase_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && ovhFlag) |=> (payPos == 2'd0));

  p_idle_no_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && e3Mode) |=> (winCnt == $past(winCnt)));

endmodule

// File: rtl/ds3mon_dp.sv
module ds3mon_dp
  import ds3mon_pkg::*;
#(
  parameter int E3_MAXZ = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       e3Mode,
  input  ctrlStb_t   stb,
  input  logic       inFrame,
  input  logic       parityOk,
  input  logic       losIn,
  input  logic       oofIn,
  output logic [1:0] fmtCode,
  output logic       idleFlag,
  output logic       yellowFlag,
  output logic       aisFlag
);

  localparam int ZW = $clog2(E3_MAXZ + 2);
  localparam logic [ZW-1:0] Z_SAT = ZW'(E3_MAXZ + 1);
  localparam logic [ZW-1:0] Z_MAX = ZW'(E3_MAXZ);

  // per-M-frame accumulators (DS3)
  logic badAis, badIdle, badFrame, cSeen, c3Seen;
  logic xA, xB, aicCur, aicPrev, aicSeen;
  // E3 state
  logic aReg;
  logic [ZW-1:0] zeroCnt;

  logic badAisNow, badIdleNow, badFrameNow, cNow, c3Now;
  logic xANow, xBNow, aicNow, aNow;
  logic goodFrame, aisDs, idleDs, yelDs;
  logic [ZW-1:0] zerosNow;
  logic aisE3, aisNext;
  logic [1:0] fmtNext;

  always_comb begin
    badAisNow = badAis | (stb.payStb & (stb.dataBit != stb.expAis));
    badIdleNow = badIdle | (stb.payStb & (stb.dataBit != stb.expIdle));
    badFrameNow = badFrame | (stb.dsBit & ~inFrame);
    cNow = cSeen | (stb.cBit & stb.dataBit);
    c3Now = c3Seen | (stb.cSub3 & stb.dataBit);
    xANow = stb.xFirst ? stb.dataBit : xA;
    xBNow = stb.xSecond ? stb.dataBit : xB;
    aicNow = stb.aicBit ? stb.dataBit : aicCur;
    aNow = stb.aBit ? stb.dataBit : aReg;

    goodFrame = ~badFrameNow & parityOk;
    aisDs = goodFrame & ~cNow & (xANow == xBNow) & ~badAisNow;
    idleDs = goodFrame & ~c3Now & (xANow == xBNow) & ~badIdleNow;
    yelDs = ~xANow & ~xBNow & ~aisDs;

    if (stb.e3Bit && !stb.dataBit && zeroCnt != Z_SAT) zerosNow = zeroCnt + 1'b1;
    else zerosNow = zeroCnt;
    aisE3 = (zerosNow <= Z_MAX);

    if (stb.frameDs) aisNext = aisDs;
    else if (stb.winEnd) aisNext = aisE3;
    else aisNext = aisFlag;

    if (aicPrev && aicNow) fmtNext = FMT_CBIT;
    else if (!aicPrev && !aicNow) fmtNext = FMT_M13;
    else fmtNext = FMT_SYNTRAN;
  end

  // DS3 frame accumulators
  always_ff @(posedge clk) begin
    if (!rstN || e3Mode) begin
      badAis <= 1'b0;
      badIdle <= 1'b0;
      badFrame <= 1'b0;
      cSeen <= 1'b0;
      c3Seen <= 1'b0;
      xA <= 1'b0;
      xB <= 1'b0;
      aicCur <= 1'b0;
    end else if (stb.frameDs) begin
      badAis <= 1'b0;
      badIdle <= 1'b0;
      badFrame <= 1'b0;
      cSeen <= 1'b0;
      c3Seen <= 1'b0;
      xA <= 1'b0;
      xB <= 1'b0;
      aicCur <= 1'b0;
    end else if (stb.dsBit) begin
      badAis <= badAisNow;
      badIdle <= badIdleNow;
      badFrame <= badFrameNow;
      cSeen <= cNow;
      c3Seen <= c3Now;
      xA <= xANow;
      xB <= xBNow;
      aicCur <= aicNow;
    end
  end

  // format code tracking
  always_ff @(posedge clk) begin
    if (!rstN || e3Mode) begin
      fmtCode <= FMT_M13;
      aicPrev <= 1'b0;
      aicSeen <= 1'b0;
    end else if (stb.frameDs) begin
      if (goodFrame) begin
        if (aicSeen) fmtCode <= fmtNext;
        aicPrev <= aicNow;
        aicSeen <= 1'b1;
      end else begin
        aicSeen <= 1'b0;
      end
    end
  end

  // E3 A-bit and zero counter
  always_ff @(posedge clk) begin
    if (!rstN || !e3Mode) begin
      aReg <= 1'b0;
      zeroCnt <= '0;
    end else begin
      if (stb.aBit) aReg <= stb.dataBit;
      if (stb.winEnd) zeroCnt <= '0;
      else if (stb.e3Bit) zeroCnt <= zerosNow;
    end
  end

  // status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aisFlag <= 1'b0;
      idleFlag <= 1'b0;
      yellowFlag <= 1'b0;
    end else begin
      aisFlag <= aisNext;
      if (e3Mode) idleFlag <= 1'b0;
      else if (stb.frameDs) idleFlag <= idleDs;
      if (losIn || oofIn) yellowFlag <= 1'b0;
      else if (stb.frameDs) yellowFlag <= yelDs;
      else if (stb.frameE3) yellowFlag <= aNow & ~aisNext;
      else if (aisNext) yellowFlag <= 1'b0;
    end
  end

  p_fmt_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    fmtCode != 2'b11);

  p_idle_ais_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(idleFlag && aisFlag));

  p_yel_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(yellowFlag) |-> $past(stb.frameDs || stb.frameE3));

  p_alarm_kills_yel_r6: assert property (@(posedge clk) disable iff (!rstN)
    (losIn || oofIn) |=> !yellowFlag);

  p_ais_kills_yel_r6: assert property (@(posedge clk) disable iff (!rstN)
    aisFlag |-> !yellowFlag);

  p_e3_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    e3Mode |=> (!idleFlag && fmtCode == 2'b00));

  p_ais_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.frameDs || stb.winEnd) |=> $stable(aisFlag));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.frameDs && !e3Mode) |=> $stable(idleFlag));

endmodule

// File: rtl/ds3_maint_det.sv
module ds3_maint_det
  import ds3mon_pkg::*;
#(
  parameter int SUB_W = 3,
  parameter int BLK_W = 3,
  parameter int E3_WIN = 1536,
  parameter int E3_MAXZ = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             e3Mode,
  input  logic             bitValid,
  input  logic             bitData,
  input  logic             ovhFlag,
  input  logic [SUB_W-1:0] subIdx,
  input  logic [BLK_W-1:0] blkIdx,
  input  logic             frameEnd,
  input  logic             inFrame,
  input  logic             parityOk,
  input  logic             losIn,
  input  logic             oofIn,
  output logic [1:0]       fmtCode,
  output logic             idleFlag,
  output logic             yellowFlag,
  output logic             aisFlag
);

  ctrlStb_t stb;

  ds3mon_ctrl #(
    .SUB_W (SUB_W),
    .BLK_W (BLK_W),
    .E3_WIN(E3_WIN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .e3Mode  (e3Mode),
    .bitValid(bitValid),
    .bitData (bitData),
    .ovhFlag (ovhFlag),
    .subIdx  (subIdx),
    .blkIdx  (blkIdx),
    .frameEnd(frameEnd),
    .stb     (stb)
  );

  ds3mon_dp #(
    .E3_MAXZ(E3_MAXZ)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .e3Mode    (e3Mode),
    .stb       (stb),
    .inFrame   (inFrame),
    .parityOk  (parityOk),
    .losIn     (losIn),
    .oofIn     (oofIn),
    .fmtCode   (fmtCode),
    .idleFlag  (idleFlag),
    .yellowFlag(yellowFlag),
    .aisFlag   (aisFlag)
  );

endmodule

// File: tb/ds3_maint_det_tb.sv
module ds3_maint_det_tb;

  localparam int WIN = 1536;
  localparam int MAXZ = 2;
  localparam int E3_LEN = 768;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic e3Mode = 1'b0;
  logic bitValid = 1'b0;
  logic bitData = 1'b0;
  logic ovhFlag = 1'b0;
  logic [2:0] subIdx = '0;
  logic [2:0] blkIdx = '0;
  logic frameEnd = 1'b0;
  logic inFrame = 1'b1;
  logic parityOk = 1'b1;
  logic losIn = 1'b0;
  logic oofIn = 1'b0;
  logic [1:0] fmtCode;
  logic idleFlag, yellowFlag, aisFlag;

  always #4 clk = ~clk;

  ds3_maint_det u_dut (
    .clk(clk), .rstN(rstN), .e3Mode(e3Mode), .bitValid(bitValid), .bitData(bitData),
    .ovhFlag(ovhFlag), .subIdx(subIdx), .blkIdx(blkIdx), .frameEnd(frameEnd),
    .inFrame(inFrame), .parityOk(parityOk), .losIn(losIn), .oofIn(oofIn),
    .fmtCode(fmtCode), .idleFlag(idleFlag), .yellowFlag(yellowFlag), .aisFlag(aisFlag)
  );

  int total = 0;
  int bad = 0;
  string tag = "R11";

  // reference model state
  int pp;
  bit mBadA, mBadI, mBadF, mC, mC3, mX1, mX2, mAic, mAicPrev, mAicOk;
  int mWin, mZeros;
  bit mA;
  bit [1:0] eFmt;
  bit eIdle, eYel, eAis;

  task automatic modelReset();
    pp = 0; mBadA = 0; mBadI = 0; mBadF = 0; mC = 0; mC3 = 0;
    mX1 = 0; mX2 = 0; mAic = 0; mAicPrev = 0; mAicOk = 0;
    mWin = 0; mZeros = 0; mA = 0;
    eFmt = 0; eIdle = 0; eYel = 0; eAis = 0;
  endtask

  task automatic modelStep(input bit v, input bit d, input bit o, input int s, input int b, input bit fe);
    bit good, nAis, nIdle, winEnd;
    if (!e3Mode) begin
      if (v) begin
        if (!inFrame) mBadF = 1;
        if (o) begin
          pp = 0;
          if (b == 0 && s == 0) mX1 = d;
          if (b == 0 && s == 1) mX2 = d;
          if (b == 2 || b == 4 || b == 6) begin
            if (d) mC = 1;
            if (d && s == 2) mC3 = 1;
            if (s == 0 && b == 2) mAic = d;
          end
        end else begin
          if (d != (pp % 2 == 0)) mBadA = 1;
          if (d != (pp % 4 < 2)) mBadI = 1;
          pp++;
        end
        if (fe) begin
          good = !mBadF && parityOk;
          nAis = good && !mC && (mX1 == mX2) && !mBadA;
          nIdle = good && !mC3 && (mX1 == mX2) && !mBadI;
          if (good) begin
            if (mAicOk) eFmt = (mAicPrev && mAic) ? 2'b01 : (!mAicPrev && !mAic) ? 2'b00 : 2'b10;
            mAicPrev = mAic;
            mAicOk = 1;
          end else mAicOk = 0;
          eAis = nAis;
          eIdle = nIdle;
          eYel = !mX1 && !mX2 && !nAis;
          mBadA = 0; mBadI = 0; mBadF = 0; mC = 0; mC3 = 0; mX1 = 0; mX2 = 0; mAic = 0;
        end
      end
    end else begin
      eIdle = 0;
      eFmt = 0;
      winEnd = 0;
      if (v) begin
        if (o) mA = d;
        if (!d) mZeros++;
        mWin++;
        if (mWin == WIN) begin
          winEnd = 1;
          eAis = (mZeros <= MAXZ);
          mZeros = 0;
          mWin = 0;
        end
        if (fe) eYel = mA && !eAis;
        else if (winEnd && eAis) eYel = 0;
      end
    end
    if (losIn || oofIn) eYel = 0;
  endtask

  task automatic chk1(input string nm, input logic act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    total++;
    if (fmtCode !== eFmt) begin
      bad++;
      $display("FAIL %s fmtCode: actual=%0b expected=%0b t=%0t", tag, fmtCode, eFmt, $time);
    end
    chk1("idleFlag", idleFlag, eIdle);
    chk1("yellowFlag", yellowFlag, eYel);
    chk1("aisFlag", aisFlag, eAis);
  endtask

  task automatic step(input bit v, input bit d, input bit o, input int s, input int b, input bit fe);
    bitValid = v; bitData = d; ovhFlag = o; subIdx = 3'(s); blkIdx = 3'(b); frameEnd = fe;
    @(posedge clk);
    @(negedge clk);
    modelStep(v, d, o, s, b, fe);
    compareAll();
  endtask

  task automatic doReset(input bit mode);
    rstN = 0; e3Mode = mode; bitValid = 0; frameEnd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    modelReset();
    tag = "R11";
    compareAll();
    rstN = 1;
  endtask

  // kind: 0 AIS payload, 1 idle payload, 2 random; cMode: 0 all C zero, 1 only subframe 2 C zero, 2 all C one
  // glitch: 1 one payload bit flipped, 2 inFrame low on one bit
  task automatic ds3Frame(input int kind, input bit x1, input bit x2, input int cMode, input bit aic, input int glitch);
    bit d, o, fe;
    for (int s = 0; s < 7; s++) begin
      for (int b = 0; b < 8; b++) begin
        for (int k = 0; k < 85; k++) begin
          o = (k == 0);
          if (o) begin
            if (b == 0) d = (s == 0) ? x1 : (s == 1) ? x2 : 1'b1;
            else if (b % 2 == 1) d = (b == 1 || b == 7);
            else if (s == 0 && b == 2) d = aic;
            else if (cMode == 0) d = 0;
            else if (cMode == 1) d = (s != 2);
            else d = 1;
          end else begin
            case (kind)
              0: d = ((k - 1) % 2 == 0);
              1: d = ((k - 1) % 4 < 2);
              default: d = 1'($urandom);
            endcase
            if (glitch == 1 && s == 4 && b == 3 && k == 50) d = ~d;
          end
          inFrame = !(glitch == 2 && s == 5 && b == 1 && k == 10);
          fe = (s == 6 && b == 7 && k == 84);
          step(1, d, o, s, b, fe);
        end
        inFrame = 1;
        step(0, 1'($urandom), 1'($urandom), s, b, 1'b0);
      end
    end
  endtask

  // kind 0: all ones with nz zeros placed in the payload, kind 1: random
  task automatic e3Frame(input int kind, input bit a, input int nz);
    bit d;
    for (int k = 0; k < E3_LEN; k++) begin
      if (k == 5) d = a;
      else if (kind == 0) d = !(k == 100 && nz > 0 || k == 200 && nz > 1 || k == 300 && nz > 2);
      else d = 1'($urandom);
      step(1, d, k == 5, 0, 0, k == E3_LEN - 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    modelReset();
    doReset(1'b0);
    tag = "R11"; step(0, 1, 1, 0, 0, 1);

    tag = "R2";  ds3Frame(0, 1, 1, 0, 0, 0);
    tag = "R4";  ds3Frame(0, 1, 1, 0, 0, 1);
    tag = "R2";  ds3Frame(0, 1, 1, 0, 0, 0);
    tag = "R2";  ds3Frame(0, 1, 1, 0, 0, 2);
    tag = "R2";  ds3Frame(0, 1, 1, 0, 0, 0);
    parityOk = 0;
    tag = "R2";  ds3Frame(0, 1, 1, 0, 0, 0);
    parityOk = 1;
    tag = "R3";  ds3Frame(1, 1, 1, 1, 1, 0);
    tag = "R4";  ds3Frame(1, 1, 1, 1, 1, 1);
    tag = "R3";  ds3Frame(1, 1, 1, 1, 1, 0);
    tag = "R3";  ds3Frame(1, 1, 0, 1, 1, 0);
    tag = "R3";  ds3Frame(1, 1, 1, 2, 1, 0);
    tag = "R5";  ds3Frame(2, 0, 0, 2, 1, 0);
    tag = "R5";  ds3Frame(2, 1, 1, 2, 0, 0);
    tag = "R6";  ds3Frame(0, 0, 0, 0, 0, 0);
    tag = "R5";  ds3Frame(2, 0, 0, 2, 1, 0);
    tag = "R6";
    oofIn = 1; step(0, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0);
    oofIn = 0; step(0, 0, 0, 0, 0, 0);
    losIn = 1;
    tag = "R6";  ds3Frame(2, 0, 0, 2, 1, 0);
    losIn = 0;
    tag = "R1";  ds3Frame(2, 1, 1, 2, 1, 0);
    tag = "R1";  ds3Frame(2, 1, 1, 2, 0, 0);
    tag = "R1";  ds3Frame(2, 1, 1, 2, 0, 0);
    tag = "R10";
    for (int i = 0; i < 20; i++) step(0, 1'($urandom), 1, 6, 7, 1);

    doReset(1'b1);
    tag = "R9";  step(0, 0, 0, 0, 0, 0);
    tag = "R8";  e3Frame(0, 1, 0); e3Frame(0, 1, 0);
    tag = "R8";  e3Frame(0, 1, 1); e3Frame(0, 1, 1);
    tag = "R8";  e3Frame(0, 1, 2); e3Frame(0, 1, 1);
    tag = "R7";  e3Frame(1, 0, 0); e3Frame(1, 1, 0);
    tag = "R6";
    losIn = 1; step(1, 1, 0, 0, 0, 0);
    losIn = 0;
    tag = "R9";  e3Frame(1, 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule